// File: doc/BRIEF.md
# Single-Channel Memory Copy Engine

This block moves a block of bytes from one place in memory to another. Software sets up a 64-bit source address, a 64-bit destination address and a byte count through a small 32-bit register port, then writes 1 to the run bit. The engine then works through the block one 32-bit word at a time. For each word it reads from the source and writes to the destination, and it uses byte strobes on the last word when the count is not a multiple of four. Source and destination addresses must be word aligned.

The run bit also serves as the busy status. It reads 1 while a copy is in progress and drops to 0 when the engine is idle again. When a copy completes, a sticky completion flag is set. A level interrupt is driven from that flag, gated by an interrupt-enable bit. Three controls can stop the engine early:
- a warm restart, which stops the engine and keeps the setup registers;
- a cold restart, which also clears every register;
- a drain bit, which holds the engine idle for as long as it is set.

Top module: `memcpy_dma_chan`

## Requirements
- R1: After reset every register reads 0, the interrupt output is 0 and no memory request is made.
- R2: The setup registers read back what was written: source low 0x1C, source high 0x60, destination low 0x20, destination high 0x64, count 0x24 and spare count 0x28. Count registers keep bits 27:0 only and read 0 above them.
- R3: Writing 1 to bit 0 at 0x08 copies count bytes. Each word is read and then written, at ascending addresses in steps of 4. The last word's strobe enables only the low (count mod 4) bytes, or all four bytes when that value is 0. Destination bytes past the count are left untouched, and exactly 2*ceil(count/4) memory accesses are made.
- R4: Bit 0 at 0x08 reads 1 from the cycle after the start write until the copy ends, and reads 0 afterwards.
- R5: Completion sets bit 0 at 0x00. Writing 0 to that bit clears it, and writing 1 does not set it.
- R6: The interrupt output is 1 exactly when the completion flag and bit 0 at 0x04 are both 1.
- R7: A count of 0 sets the completion flag without any memory access, and the run bit stays 0.
- R8: Writes to the address and count registers are ignored while the engine is busy.
- R9: Writing 1 to bit 0 at 0x0C stops the engine without setting the flag and keeps the address and count registers. The 0x0C register always reads 0.
- R10: Writing 1 to bit 1 at 0x0C stops the engine and clears every register, including the flag, interrupt enable and drain bit.
- R11: While bit 0 at 0x14 is 1, the engine is idle, the flag is not set by the stop, and start writes are ignored. The bit reads back until software clears it.
- R12: Bits 63:32 of every memory address come from the high address registers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_valid | input | 1 | Register access request |
| reg_write | input | 1 | 1 = write, 0 = read |
| reg_addr | input | 8 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_ready | output | 1 | Access accepted (always 1) |
| reg_rdata | output | 32 | Register read data, valid in the access cycle |
| mem_req | output | 1 | Memory request, held until mem_ready |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 64 | Word-aligned byte address |
| mem_wdata | output | 32 | Write data |
| mem_wstrb | output | 4 | Byte enables for writes |
| mem_ready | input | 1 | Access completes this cycle |
| mem_rdata | input | 32 | Read data, valid with mem_ready |
| irq | output | 1 | Level interrupt |

## Verification
The copy path is swept over counts 0 to 19, which cover every final-strobe pattern and the zero-count case. The sweep also rotates the source and destination word offsets and the memory wait states from 0 to 2. Strobe errors show up as a corrupted guard byte placed just past the destination. Errors in word stepping or address increments show up as mismatched data or a wrong access count. Handshake errors show up only under wait states. A separate copy uses non-zero high address words to separate the two halves of the address. Separate runs stop a long copy with each of the three stop controls, so warm restart, cold restart and drain can be told apart by which registers survive.

// File: rtl/mcd_pkg.sv
package mcd_pkg;
    localparam int REG_AW  = 8;
    localparam int DATA_W  = 32;
    localparam int ADDR_W  = 64;
    localparam int LEN_W   = 28;
    localparam int STRB_W  = DATA_W / 8;

    localparam logic [REG_AW-1:0] OFS_FLAG   = 8'h00;
    localparam logic [REG_AW-1:0] OFS_IEN    = 8'h04;
    localparam logic [REG_AW-1:0] OFS_RUN    = 8'h08;
    localparam logic [REG_AW-1:0] OFS_RST    = 8'h0C;
    localparam logic [REG_AW-1:0] OFS_DRAIN  = 8'h14;
    localparam logic [REG_AW-1:0] OFS_SRC_LO = 8'h1C;
    localparam logic [REG_AW-1:0] OFS_DST_LO = 8'h20;
    localparam logic [REG_AW-1:0] OFS_CNT    = 8'h24;
    localparam logic [REG_AW-1:0] OFS_CNT2   = 8'h28;
    localparam logic [REG_AW-1:0] OFS_SRC_HI = 8'h60;
    localparam logic [REG_AW-1:0] OFS_DST_HI = 8'h64;

    typedef enum logic [1:0] {ENG_IDLE, ENG_READ, ENG_WRITE} eng_state_e;

    typedef struct packed {
        logic [ADDR_W-1:0] src;
        logic [ADDR_W-1:0] dst;
        logic [LEN_W-1:0]  cnt;
    } xfer_cfg_t;

    function automatic logic [STRB_W-1:0] tail_strb(input logic [LEN_W-1:0] rem);
        if (rem >= LEN_W'(STRB_W)) return '1;
        return STRB_W'((1 << rem[1:0]) - 1);
    endfunction
endpackage

// File: rtl/mcd_regs.sv
module mcd_regs
    import mcd_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                reg_valid,
    input  logic                reg_write,
    input  logic [REG_AW-1:0]   reg_addr,
    input  logic [DATA_W-1:0]   reg_wdata,
    output logic [DATA_W-1:0]   reg_rdata,
    input  logic                busy,
    input  logic                done,
    output xfer_cfg_t           cfg,
    output logic                flag,
    output logic                ien,
    output logic                drain,
    output logic                start,
    output logic                abort,
    output logic                cfg_wr
);
    logic [DATA_W-1:0] src_lo, src_hi, dst_lo, dst_hi;
    logic [LEN_W-1:0]  cnt, cnt2;
    logic wr, warm, cold;

    assign wr    = reg_valid && reg_write;
    assign warm  = wr && reg_addr == OFS_RST && reg_wdata[0];
    assign cold  = wr && reg_addr == OFS_RST && reg_wdata[1];
    assign abort = drain || warm || cold;
    assign start = wr && reg_addr == OFS_RUN && reg_wdata[0] && !busy && !drain;
    assign cfg_wr = wr && (reg_addr == OFS_SRC_LO || reg_addr == OFS_SRC_HI ||
                           reg_addr == OFS_DST_LO || reg_addr == OFS_DST_HI ||
                           reg_addr == OFS_CNT    || reg_addr == OFS_CNT2);
    assign cfg = '{src: {src_hi, src_lo}, dst: {dst_hi, dst_lo}, cnt: cnt};

    always_ff @(posedge clk) begin
        if (rst || cold) begin
            src_lo <= '0; src_hi <= '0; dst_lo <= '0; dst_hi <= '0;
            cnt <= '0; cnt2 <= '0; flag <= 1'b0; ien <= 1'b0; drain <= 1'b0;
        end else begin
            if (cfg_wr && !busy) begin
                case (reg_addr)
                    OFS_SRC_LO: src_lo <= reg_wdata;
                    OFS_SRC_HI: src_hi <= reg_wdata;
                    OFS_DST_LO: dst_lo <= reg_wdata;
                    OFS_DST_HI: dst_hi <= reg_wdata;
                    OFS_CNT:    cnt    <= reg_wdata[LEN_W-1:0];
                    OFS_CNT2:   cnt2   <= reg_wdata[LEN_W-1:0];
                    default: ;
                endcase
            end
            if (wr && reg_addr == OFS_IEN)   ien   <= reg_wdata[0];
            if (wr && reg_addr == OFS_DRAIN) drain <= reg_wdata[0];
            if (done)
                flag <= 1'b1;
            else if (wr && reg_addr == OFS_FLAG)
                flag <= flag & reg_wdata[0];
        end
    end

    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            OFS_FLAG:   reg_rdata[0] = flag;
            OFS_IEN:    reg_rdata[0] = ien;
            OFS_RUN:    reg_rdata[0] = busy;
            OFS_DRAIN:  reg_rdata[0] = drain;
            OFS_SRC_LO: reg_rdata = src_lo;
            OFS_SRC_HI: reg_rdata = src_hi;
            OFS_DST_LO: reg_rdata = dst_lo;
            OFS_DST_HI: reg_rdata = dst_hi;
            OFS_CNT:    reg_rdata = DATA_W'(cnt);
            OFS_CNT2:   reg_rdata = DATA_W'(cnt2);
            default:    reg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/mcd_engine.sv
module mcd_engine
    import mcd_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                start,
    input  logic                abort,
    input  xfer_cfg_t           cfg,
    output logic                busy,
    output logic                done,
    output logic                mem_req,
    output logic                mem_we,
    output logic [ADDR_W-1:0]   mem_addr,
    output logic [DATA_W-1:0]   mem_wdata,
    output logic [STRB_W-1:0]   mem_wstrb,
    input  logic                mem_ready,
    input  logic [DATA_W-1:0]   mem_rdata
);
    eng_state_e        state;
    logic [ADDR_W-1:0] cur_src, cur_dst;
    logic [LEN_W-1:0]  rem;
    logic [DATA_W-1:0] word_q;
    logic              last_word;

    assign busy      = state != ENG_IDLE;
    assign last_word = rem <= LEN_W'(STRB_W);
    assign mem_req   = busy;
    assign mem_we    = state == ENG_WRITE;
    assign mem_addr  = (state == ENG_WRITE) ? cur_dst : cur_src;
    assign mem_wdata = word_q;
    assign mem_wstrb = (state == ENG_WRITE) ? tail_strb(rem) : '0;
    assign done = !abort && ((start && cfg.cnt == '0) ||
                  (state == ENG_WRITE && mem_ready && last_word));

    always_ff @(posedge clk) begin
        if (rst || abort) begin
            state <= ENG_IDLE;
        end else begin
            case (state)
                ENG_IDLE: if (start && cfg.cnt != '0) begin
                    state   <= ENG_READ;
                    cur_src <= cfg.src;
                    cur_dst <= cfg.dst;
                    rem     <= cfg.cnt;
                end
                ENG_READ: if (mem_ready) begin
                    word_q <= mem_rdata;
                    state  <= ENG_WRITE;
                end
                ENG_WRITE: if (mem_ready) begin
                    if (last_word) begin
                        state <= ENG_IDLE;
                    end else begin
                        rem     <= rem - LEN_W'(STRB_W);
                        cur_src <= cur_src + ADDR_W'(STRB_W);
                        cur_dst <= cur_dst + ADDR_W'(STRB_W);
                        state   <= ENG_READ;
                    end
                end
                default: state <= ENG_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/memcpy_dma_chan.sv
module memcpy_dma_chan
    import mcd_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                reg_valid,
    input  logic                reg_write,
    input  logic [REG_AW-1:0]   reg_addr,
    input  logic [DATA_W-1:0]   reg_wdata,
    output logic                reg_ready,
    output logic [DATA_W-1:0]   reg_rdata,
    output logic                mem_req,
    output logic                mem_we,
    output logic [ADDR_W-1:0]   mem_addr,
    output logic [DATA_W-1:0]   mem_wdata,
    output logic [STRB_W-1:0]   mem_wstrb,
    input  logic                mem_ready,
    input  logic [DATA_W-1:0]   mem_rdata,
    output logic                irq
);
    xfer_cfg_t cfg;
    logic busy, done, flag, ien, drain, start, abort, cfg_wr;

    assign reg_ready = 1'b1;
    assign irq = flag && ien;

    mcd_regs u_regs (
        .clk, .rst, .reg_valid, .reg_write, .reg_addr, .reg_wdata, .reg_rdata,
        .busy, .done, .cfg, .flag, .ien, .drain, .start, .abort, .cfg_wr
    );

    mcd_engine u_eng (
        .clk, .rst, .start, .abort, .cfg, .busy, .done,
        .mem_req, .mem_we, .mem_addr, .mem_wdata, .mem_wstrb, .mem_ready, .mem_rdata
    );
endmodule

// File: rtl/mcd_checker.sv
module mcd_checker
    import mcd_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              busy,
    input logic              done,
    input logic              flag,
    input logic              drain,
    input logic              start,
    input logic              abort,
    input logic              cfg_wr,
    input xfer_cfg_t         cfg,
    input logic              mem_req,
    input logic              mem_we,
    input logic              mem_ready,
    input logic [ADDR_W-1:0] mem_addr
);
    // R3: a pending request holds its address and direction
    a_r3_req_hold: assert property (@(posedge clk) disable iff (rst)
        mem_req && !mem_ready && !abort |=> mem_req && $stable(mem_addr) && $stable(mem_we));
    // R4: no memory traffic while the run bit reads 0
    a_r4_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !mem_req);
    // R5: the flag only rises after an engine completion
    a_r5_flag_cause: assert property (@(posedge clk) disable iff (rst)
        $rose(flag) |-> $past(done));
    // R7: zero count finishes at once
    a_r7_zero_count: assert property (@(posedge clk) disable iff (rst)
        start && cfg.cnt == '0 |=> !busy && flag);
    // R8: setup registers frozen while busy
    a_r8_busy_freeze: assert property (@(posedge clk) disable iff (rst)
        busy && cfg_wr && !abort |=> $stable(cfg));
    // R11: drain holds the engine idle
    a_r11_drain_idle: assert property (@(posedge clk) disable iff (rst)
        drain |=> !busy);
endmodule

bind memcpy_dma_chan mcd_checker u_chk (
    .clk(clk), .rst(rst), .busy(busy), .done(done), .flag(flag), .drain(drain),
    .start(start), .abort(abort), .cfg_wr(cfg_wr), .cfg(cfg), .mem_req(mem_req),
    .mem_we(mem_we), .mem_ready(mem_ready), .mem_addr(mem_addr)
);

// File: tb/memcpy_dma_chan_test.sv
module memcpy_dma_chan_test;
    logic clk = 0, rst = 1;
    logic reg_valid = 0, reg_write = 0;
    logic [7:0] reg_addr = 0;
    logic [31:0] reg_wdata = 0;
    logic reg_ready;
    logic [31:0] reg_rdata;
    logic mem_req, mem_we, mem_ready, irq;
    logic [63:0] mem_addr;
    logic [31:0] mem_wdata, mem_rdata;
    logic [3:0] mem_wstrb;

    logic [7:0] mem [0:1023];
    int lat = 0, wcnt = 0, acc_cnt = 0, hi_err = 0, cycles = 0;
    logic [31:0] exp_hi = 0;
    int n_chk = 0, n_fail = 0;
    logic [31:0] rd;

    always #5 clk = ~clk;

    memcpy_dma_chan uut (
        .clk, .rst, .reg_valid, .reg_write, .reg_addr, .reg_wdata, .reg_ready, .reg_rdata,
        .mem_req, .mem_we, .mem_addr, .mem_wdata, .mem_wstrb, .mem_ready, .mem_rdata, .irq
    );

    assign mem_ready = mem_req && (wcnt >= lat);
    assign mem_rdata = {mem[{mem_addr[9:2], 2'd3}], mem[{mem_addr[9:2], 2'd2}],
                        mem[{mem_addr[9:2], 2'd1}], mem[{mem_addr[9:2], 2'd0}]};

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (mem_req && !mem_ready) wcnt <= wcnt + 1; else wcnt <= 0;
        if (mem_req && mem_ready) begin
            acc_cnt <= acc_cnt + 1;
            if (mem_addr[63:32] != exp_hi) hi_err <= hi_err + 1;
            if (mem_we)
                for (int b = 0; b < 4; b++)
                    if (mem_wstrb[b]) mem[{mem_addr[9:2], 2'(b)}] <= mem_wdata[8*b +: 8];
        end
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_valid = 1; reg_write = 1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_valid = 0; reg_write = 0;
    endtask

    task automatic rdreg(input logic [7:0] a, output logic [31:0] d);
        reg_valid = 1; reg_write = 0; reg_addr = a;
        #1 d = reg_rdata;
        @(negedge clk);
        reg_valid = 0;
    endtask

    task automatic wait_idle();
        logic [31:0] v;
        for (int i = 0; i < 2000; i++) begin
            rdreg(8'h08, v);
            if (v[0] == 1'b0) break;
        end
    endtask

    task automatic setup(input int len, input int soff, input int doff, input logic [31:0] hi);
        wr(8'h1C, 32'h040 + soff); wr(8'h60, hi);
        wr(8'h20, 32'h200 + doff); wr(8'h64, hi);
        wr(8'h24, len);
    endtask

    task automatic run_copy(input int len, input int soff, input int doff, input int l,
                            input logic [31:0] hi, input string req);
        int a0, bad;
        for (int i = 0; i < 1024; i++) mem[i] = (i < 512) ? 8'((i * 7 + len) ^ 8'h5A) : 8'hEE;
        lat = l; exp_hi = hi;
        setup(len, soff, doff, hi);
        wr(8'h00, 0);
        a0 = acc_cnt; hi_err = 0;
        wr(8'h08, 1);
        wait_idle();
        bad = 0;
        for (int i = 0; i < len; i++)
            if (mem[32'h200 + doff + i] !== mem[32'h040 + soff + i]) bad++;
        if (mem[32'h200 + doff + len] !== 8'hEE) bad++;
        chk(bad == 0, {req, " data"}, bad, 0);
        chk(acc_cnt - a0 == 2 * ((len + 3) / 4), {req, " access count"}, acc_cnt - a0, 2 * ((len + 3) / 4));
        rdreg(8'h00, rd);
        chk(rd == 1, "R5 flag after copy", rd, 1);
        chk(hi_err == 0, "R12 high address bits", hi_err, 0);
    endtask

    initial begin
        int a0;
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R1: reset state
        begin
            int nz = 0;
            foreach (mcd_pkg::OFS_FLAG[i]) ;
            for (int a = 0; a < 8'h68; a += 4) begin rdreg(8'(a), rd); if (rd != 0) nz++; end
            chk(nz == 0 && !irq && !mem_req, "R1 reset state", nz, 0);
        end
        // R2: readback and count width
        wr(8'h1C, 32'h1234_5678); rdreg(8'h1C, rd); chk(rd == 32'h1234_5678, "R2 src lo", rd, 32'h1234_5678);
        wr(8'h64, 32'hCAFE_0001); rdreg(8'h64, rd); chk(rd == 32'hCAFE_0001, "R2 dst hi", rd, 32'hCAFE_0001);
        wr(8'h24, 32'hFFFF_FFFF); rdreg(8'h24, rd); chk(rd == 32'h0FFF_FFFF, "R2 count width", rd, 32'h0FFF_FFFF);
        wr(8'h28, 32'hF000_0ABC); rdreg(8'h28, rd); chk(rd == 32'h0000_0ABC, "R2 spare count", rd, 32'h0000_0ABC);
        // R3/R7: sweep of counts, offsets and wait states
        for (int len = 0; len < 20; len++)
            run_copy(len, 4 * (len % 4), 4 * ((len / 4) % 3), len % 3, 0, len == 0 ? "R7" : "R3");
        // R12: non-zero high words
        run_copy(13, 8, 12, 1, 32'h0000_00A5, "R12");
        // R4: run bit during and after
        for (int i = 0; i < 1024; i++) mem[i] = 8'(i);
        lat = 2; exp_hi = 0; setup(32, 0, 0, 0);
        wr(8'h08, 1); rdreg(8'h08, rd); chk(rd == 1, "R4 busy while copying", rd, 1);
        // R8: setup write ignored while busy
        wr(8'h1C, 32'h0BAD); wr(8'h24, 3);
        wait_idle(); rdreg(8'h08, rd); chk(rd == 0, "R4 idle after copy", rd, 0);
        rdreg(8'h1C, rd); chk(rd == 32'h040, "R8 src kept", rd, 32'h040);
        rdreg(8'h24, rd); chk(rd == 32, "R8 count kept", rd, 32);
        // R5/R6: flag and interrupt
        chk(irq == 0, "R6 irq masked", irq, 0);
        wr(8'h04, 1); chk(irq == 1, "R6 irq enabled", irq, 1);
        wr(8'h00, 0); rdreg(8'h00, rd); chk(rd == 0 && irq == 0, "R5 flag cleared", rd, 0);
        wr(8'h00, 1); rdreg(8'h00, rd); chk(rd == 0, "R5 write 1 no set", rd, 0);
        // R11: drain
        setup(64, 0, 0, 0); lat = 2;
        wr(8'h08, 1); repeat (5) @(negedge clk);
        wr(8'h14, 1); @(negedge clk);
        rdreg(8'h08, rd); chk(rd == 0, "R11 drain stops", rd, 0);
        rdreg(8'h00, rd); chk(rd == 0, "R11 no flag", rd, 0);
        a0 = acc_cnt; wr(8'h08, 1); repeat (4) @(negedge clk);
        rdreg(8'h08, rd); chk(rd == 0 && acc_cnt == a0, "R11 start ignored", acc_cnt - a0, 0);
        rdreg(8'h14, rd); chk(rd == 1, "R11 drain readback", rd, 1);
        wr(8'h14, 0);
        // R9: warm restart
        wr(8'h08, 1); repeat (4) @(negedge clk);
        wr(8'h0C, 1); @(negedge clk);
        rdreg(8'h08, rd); chk(rd == 0, "R9 warm stops", rd, 0);
        rdreg(8'h1C, rd); chk(rd == 32'h040, "R9 src kept", rd, 32'h040);
        rdreg(8'h24, rd); chk(rd == 64, "R9 count kept", rd, 64);
        rdreg(8'h0C, rd); chk(rd == 0, "R9 restart reads 0", rd, 0);
        rdreg(8'h00, rd); chk(rd == 0, "R9 no flag", rd, 0);
        // R10: cold restart
        wr(8'h04, 1); wr(8'h24, 4); wr(8'h08, 1); wait_idle();
        chk(irq == 1, "R6 irq on completion", irq, 1);
        wr(8'h24, 64); wr(8'h08, 1); repeat (4) @(negedge clk);
        wr(8'h0C, 2); @(negedge clk);
        begin
            int nz = 0;
            for (int a = 0; a < 8'h68; a += 4) begin rdreg(8'(a), rd); if (rd != 0) nz++; end
            chk(nz == 0 && !irq && !mem_req, "R10 cold clears all", nz, 0);
        end
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        wait (cycles > 150000);
        n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule